// File: doc/BRIEF.md
# Outbound Address Window Translator

This block maps outgoing 64-bit request addresses onto a downstream address space. It uses a bank of programmable windows, eight by default. Each window holds a 64-bit match value, a 64-bit compare mask, a 64-bit remap base and a 32-bit action word. Bit 0 of the low match word switches the window on.

An address hits a window when it agrees with the match value on every bit the mask selects. Mask bit 0 never takes part in the compare, because that bit of the match word is the enable. On a hit, the masked bits of the address are replaced with the remap base. The unmasked bits pass through unchanged, and the window's action word goes out with the result. The action word carries the request type code (memory 0x0, I/O 0x4) and may carry attribute bits.

Software programs the windows through a simple 32-bit register write/read port. It should write every field first and set the enable bit last. A global enable bit in a separate control register must also be set before any window can hit. Requests enter through a valid/ready handshake, and each result leaves through a registered valid/ready output one cycle later.

Top module: `obwin_xlate`

## Requirements
- R1: After reset, every window register and the global enable read zero, `rsp_valid_o` is low and `req_ready_o` is high.
- R2: Window `w` occupies register byte offsets `w*0x20` to `w*0x20+0x1B`. Its word fields are: match low at +0x00, match high at +0x04, remap low at +0x08, remap high at +0x0C, mask low at +0x10, mask high at +0x14 and action at +0x18. Writes to these fields read back unchanged. Offset +0x1C reads zero and ignores writes. The global enable is bit 0 of the control word at `NUM_WIN*0x20` (0x100 by default), and the other bits of that word read zero.
- R3: A window hits when its enable (match low bit 0) is 1 and `(addr ^ match) & mask` is zero over bits 63..1. Address bit 0 is never compared.
- R4: On a hit, `rsp_addr_o = (remap & mask) | (addr & ~mask)`, using the full 64-bit mask.
- R5: On a hit, `rsp_hit_o` is 1, `rsp_win_o` gives the window index and `rsp_action_o` gives that window's action word.
- R6: When several windows hit, the one with the lowest index is used.
- R7: On a miss, `rsp_addr_o` equals the request address, and `rsp_hit_o`, `rsp_win_o` and `rsp_action_o` are all zero.
- R8: While the global enable is 0, every request misses, whatever the window settings are.
- R9: A request accepted on a clock edge (`req_valid_i && req_ready_o`) produces its result with `rsp_valid_o` high after that same edge. The result holds steady while `rsp_ready_i` is low. `req_ready_o` is high whenever the output stage is empty or being drained.
- R10: A window whose enable bit is 0 never hits, even when its masked compare agrees.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | REG_AW | Register byte address (write and read) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready |
| req_addr_i | input | 64 | Request address |
| rsp_valid_o | output | 1 | Result valid |
| rsp_ready_i | input | 1 | Result ready |
| rsp_addr_o | output | 64 | Translated or pass-through address |
| rsp_hit_o | output | 1 | A window matched |
| rsp_win_o | output | IDX_W | Index of the matching window |
| rsp_action_o | output | 32 | Action word of the matching window |

## Verification
Each translation result appears after the clock edge that accepts the request, with exactly one register stage on the way. The driver therefore checks `rsp_valid_o` at the falling edge right after its handshake edge. A scoreboard queue orders the expected results, and the monitor compares them at each falling edge where `rsp_valid_o` and `rsp_ready_i` are both high. When the output is held back by backpressure, the monitor checks at the following falling edge that the stalled result has not changed. Register readback is combinational, so it is checked one time step after the address is set.

// File: rtl/obwin_pkg.sv
package obwin_pkg;
  localparam int XW = 64;
  localparam int DW = 32;

  // word index of each field inside a 0x20-byte window block
  localparam logic [2:0] F_MATCH_LO = 3'd0;
  localparam logic [2:0] F_MATCH_HI = 3'd1;
  localparam logic [2:0] F_REMAP_LO = 3'd2;
  localparam logic [2:0] F_REMAP_HI = 3'd3;
  localparam logic [2:0] F_MASK_LO  = 3'd4;
  localparam logic [2:0] F_MASK_HI  = 3'd5;
  localparam logic [2:0] F_ACTION   = 3'd6;

  typedef struct packed {
    logic [DW-1:0] match_lo;
    logic [DW-1:0] match_hi;
    logic [DW-1:0] remap_lo;
    logic [DW-1:0] remap_hi;
    logic [DW-1:0] mask_lo;
    logic [DW-1:0] mask_hi;
    logic [DW-1:0] action;
  } win_cfg_t;
endpackage

// File: rtl/obwin_regs.sv
module obwin_regs
  import obwin_pkg::*;
#(
  parameter int NUM_WIN = 8,
  parameter int REG_AW  = 9
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_i,
  input  logic [REG_AW-1:0]           addr_i,
  input  logic [DW-1:0]               wdata_i,
  output logic [DW-1:0]               rdata_o,
  output win_cfg_t [NUM_WIN-1:0]      win_o,
  output logic                        glb_en_o
);
  localparam int BLK_W = REG_AW - 5;
  localparam logic [REG_AW-1:0] CTRL_ADDR = REG_AW'(NUM_WIN * 32);

  logic [BLK_W-1:0] blk;
  logic [2:0]       fld;
  logic             is_win;
  logic             glb_q;
  win_cfg_t [NUM_WIN-1:0] win_q;

  assign blk    = addr_i[REG_AW-1:5];
  assign fld    = addr_i[4:2];
  assign is_win = (blk < BLK_W'(NUM_WIN));

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic we;
    assign we = wr_i && is_win && (blk == BLK_W'(w));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        win_q[w] <= '0;
      end else if (we) begin
        case (fld)
          F_MATCH_LO: win_q[w].match_lo <= wdata_i;
          F_MATCH_HI: win_q[w].match_hi <= wdata_i;
          F_REMAP_LO: win_q[w].remap_lo <= wdata_i;
          F_REMAP_HI: win_q[w].remap_hi <= wdata_i;
          F_MASK_LO:  win_q[w].mask_lo  <= wdata_i;
          F_MASK_HI:  win_q[w].mask_hi  <= wdata_i;
          F_ACTION:   win_q[w].action   <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        glb_q <= 1'b0;
    else if (wr_i && addr_i == CTRL_ADDR) glb_q <= wdata_i[0];
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == CTRL_ADDR) begin
      rdata_o = {{(DW-1){1'b0}}, glb_q};
    end else begin
      for (int w = 0; w < NUM_WIN; w++) begin
        if (is_win && blk == BLK_W'(w)) begin
          case (fld)
            F_MATCH_LO: rdata_o = win_q[w].match_lo;
            F_MATCH_HI: rdata_o = win_q[w].match_hi;
            F_REMAP_LO: rdata_o = win_q[w].remap_lo;
            F_REMAP_HI: rdata_o = win_q[w].remap_hi;
            F_MASK_LO:  rdata_o = win_q[w].mask_lo;
            F_MASK_HI:  rdata_o = win_q[w].mask_hi;
            F_ACTION:   rdata_o = win_q[w].action;
            default:    rdata_o = '0;
          endcase
        end
      end
    end
  end

  assign win_o    = win_q;
  assign glb_en_o = glb_q;

  // R2
  glb_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == CTRL_ADDR) |=> (glb_en_o == $past(wdata_i[0])));
endmodule

// File: rtl/obwin_match.sv
module obwin_match
  import obwin_pkg::*;
#(
  parameter int NUM_WIN = 8
) (
  input  win_cfg_t [NUM_WIN-1:0] win_i,
  input  logic                   glb_en_i,
  input  logic [XW-1:0]          addr_i,
  output logic [NUM_WIN-1:0]     hit_o
);
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    logic [XW-1:0] cmp_mask;
    logic [XW-1:0] match;
    assign cmp_mask = {win_i[w].mask_hi, win_i[w].mask_lo} & ~XW'(1);
    assign match    = {win_i[w].match_hi, win_i[w].match_lo};
    assign hit_o[w] = glb_en_i & win_i[w].match_lo[0] &
                      ~|((addr_i ^ match) & cmp_mask);
  end
endmodule

// File: rtl/obwin_prio.sv
module obwin_prio #(
  parameter int NUM_WIN = 8,
  parameter int IDX_W   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_WIN-1:0] hit_i,
  output logic [NUM_WIN-1:0] sel_oh_o,
  output logic [IDX_W-1:0]   sel_idx_o,
  output logic               any_o
);
  always_comb begin
    sel_oh_o  = '0;
    sel_idx_o = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (hit_i[w]) begin
        sel_oh_o    = '0;
        sel_oh_o[w] = 1'b1;
        sel_idx_o   = IDX_W'(w);
      end
    end
  end
  assign any_o = |hit_i;

  // R6
  sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_oh_o) && ((sel_oh_o & ~hit_i) == '0));
  // R6
  lowest_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o |-> (((sel_oh_o - NUM_WIN'(1)) & hit_i) == '0) && (sel_oh_o != '0));
endmodule

// File: rtl/obwin_xlate.sv
module obwin_xlate
  import obwin_pkg::*;
#(
  parameter int NUM_WIN = 8,
  parameter int REG_AW  = $clog2(NUM_WIN * 32) + 1,
  parameter int IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [63:0]       req_addr_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [63:0]       rsp_addr_o,
  output logic              rsp_hit_o,
  output logic [IDX_W-1:0]  rsp_win_o,
  output logic [31:0]       rsp_action_o
);
  win_cfg_t [NUM_WIN-1:0] win_cfg;
  logic                   glb_en;
  logic [NUM_WIN-1:0]     hit_vec, sel_oh;
  logic [IDX_W-1:0]       sel_idx;
  logic                   any_hit, acc;
  win_cfg_t               sel_cfg;
  logic [XW-1:0]          sel_mask, xl_addr;

  obwin_regs #(.NUM_WIN(NUM_WIN), .REG_AW(REG_AW)) u_regs (
    .clk_i, .rst_ni, .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .win_o(win_cfg), .glb_en_o(glb_en)
  );

  obwin_match #(.NUM_WIN(NUM_WIN)) u_match (
    .win_i(win_cfg), .glb_en_i(glb_en), .addr_i(req_addr_i), .hit_o(hit_vec)
  );

  obwin_prio #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_prio (
    .clk_i, .rst_ni, .hit_i(hit_vec), .sel_oh_o(sel_oh),
    .sel_idx_o(sel_idx), .any_o(any_hit)
  );

  always_comb begin
    sel_cfg = '0;
    for (int w = 0; w < NUM_WIN; w++)
      if (sel_oh[w]) sel_cfg = win_cfg[w];
  end

  assign sel_mask = {sel_cfg.mask_hi, sel_cfg.mask_lo};
  assign xl_addr  = ({sel_cfg.remap_hi, sel_cfg.remap_lo} & sel_mask) |
                    (req_addr_i & ~sel_mask);

  assign req_ready_o = !rsp_valid_o || rsp_ready_i;
  assign acc         = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rsp_addr_o   <= '0;
      rsp_hit_o    <= 1'b0;
      rsp_win_o    <= '0;
      rsp_action_o <= '0;
    end else begin
      if (acc) begin
        rsp_valid_o  <= 1'b1;
        rsp_addr_o   <= any_hit ? xl_addr : req_addr_i;
        rsp_hit_o    <= any_hit;
        rsp_win_o    <= any_hit ? sel_idx : '0;
        rsp_action_o <= any_hit ? sel_cfg.action : '0;
      end else if (rsp_ready_i) begin
        rsp_valid_o  <= 1'b0;
      end
    end
  end

  // R9
  accept_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> rsp_valid_o);
  // R9
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> rsp_valid_o && $stable(rsp_addr_o) &&
      $stable(rsp_hit_o) && $stable(rsp_action_o) && $stable(rsp_win_o));
  // R7
  miss_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !any_hit) |=> !rsp_hit_o && (rsp_addr_o == $past(req_addr_i)));
  // R8
  glb_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !glb_en) |=> !rsp_hit_o);
endmodule

// File: tb/obwin_xlate_tb.sv
`timescale 1ns/1ps
module obwin_xlate_tb_top;
  typedef struct {
    logic [63:0] addr;
    logic        hit;
    logic [2:0]  win;
    logic [31:0] act;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [8:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [63:0] rsp_addr;
  logic        rsp_hit;
  logic [2:0]  rsp_win;
  logic [31:0] rsp_action;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit bp_on = 0;
  bit glb = 0;
  logic [31:0] sh [8][7];
  exp_t q[$];

  always #2.5 clk = ~clk;

  obwin_xlate dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_addr_o(rsp_addr),
    .rsp_hit_o(rsp_hit), .rsp_win_o(rsp_win), .rsp_action_o(rsp_action)
  );

  task automatic chk(bit ok, string r, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
    end
  endtask

  function automatic exp_t model(logic [63:0] a, string tag);
    exp_t e;
    logic [63:0] mk, m;
    e.addr = a; e.hit = 0; e.win = 0; e.act = 0; e.tag = tag;
    if (glb) begin
      for (int w = 7; w >= 0; w--) begin
        mk = {sh[w][5], sh[w][4]};
        m  = {sh[w][1], sh[w][0]};
        if (sh[w][0][0] && (((a ^ m) & mk & ~64'd1) == 0)) begin
          e.hit = 1; e.win = 3'(w); e.act = sh[w][6];
          e.addr = ({sh[w][3], sh[w][2]} & mk) | (a & ~mk);
        end
      end
    end
    return e;
  endfunction

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wr(int w, int f, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = 9'(w * 32 + f * 4); reg_wdata = d;
    if (f < 7) sh[w][f] = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic wr_ctrl(logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = 9'h100; reg_wdata = d; glb = d[0];
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd_chk(logic [8:0] a, logic [31:0] exp, string r);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(reg_rdata == exp, r, $sformatf("readback @%h", a), 64'(reg_rdata), 64'(exp));
  endtask

  task automatic send(logic [63:0] a, string tag);
    bit r;
    q.push_back(model(a, tag));
    req_valid = 1; req_addr = a;
    forever begin
      r = req_ready;
      @(negedge clk);
      if (r) break;
    end
    req_valid = 0;
    chk(rsp_valid == 1'b1, "R9", "valid one cycle after accept", 64'(rsp_valid), 64'd1);
  endtask

  // backpressure source, changes just after the rising edge
  initial begin
    int c = 0;
    forever begin
      @(posedge clk); #1;
      c++;
      rsp_ready = bp_on ? ((c % 3) != 0) : 1'b1;
    end
  end

  // monitor: pop and compare on output handshakes; check stall stability
  initial begin
    bit stalled = 0;
    logic [63:0] h_addr;
    logic [31:0] h_act;
    forever begin
      @(negedge clk);
      if (rst_n && stalled && rsp_valid)
        chk(rsp_addr == h_addr && rsp_action == h_act, "R9", "held under stall",
            rsp_addr, h_addr);
      stalled = 0;
      if (rst_n && rsp_valid && !rsp_ready) begin
        stalled = 1; h_addr = rsp_addr; h_act = rsp_action;
      end
      if (rst_n && rsp_valid && rsp_ready) begin
        if (q.size() == 0) begin
          chk(0, "R9", "unexpected result", rsp_addr, 64'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(rsp_addr == e.addr, e.tag, "addr", rsp_addr, e.addr);
          chk(rsp_hit == e.hit, e.tag, "hit", 64'(rsp_hit), 64'(e.hit));
          chk(rsp_win == e.win, e.tag, "win", 64'(rsp_win), 64'(e.win));
          chk(rsp_action == e.act, e.tag, "action", 64'(rsp_action), 64'(e.act));
        end
      end
    end
  end

  initial begin
    #(5ns * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < 8; w++) for (int f = 0; f < 7; f++) sh[w][f] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(rsp_valid == 0, "R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
    chk(req_ready == 1, "R1", "req_ready after reset", 64'(req_ready), 64'd1);
    rd_chk(9'h000, 32'h0, "R1");
    rd_chk(9'h0F8, 32'h0, "R1");
    rd_chk(9'h100, 32'h0, "R1");

    // R2 register map readback
    for (int f = 0; f < 7; f++) wr(3, f, 32'hA500_0000 + 32'(f * 16 + 3));
    for (int f = 0; f < 7; f++) rd_chk(9'(3 * 32 + f * 4), 32'hA500_0000 + 32'(f * 16 + 3), "R2");
    wr(3, 7, 32'hDEAD_BEEF);
    rd_chk(9'h07C, 32'h0, "R2");
    wr_ctrl(32'hFFFF_FFFF);
    rd_chk(9'h100, 32'h1, "R2");
    wr_ctrl(32'h0);
    rd_chk(9'h100, 32'h0, "R2");
    for (int f = 0; f < 7; f++) wr(3, f, 32'h0);

    // R8 global enable off: window 0 matches everything but must not hit
    wr(0, 4, 32'h0); wr(0, 6, 32'h0000_0004); wr(0, 0, 32'h1);
    send(64'h0000_0000_1234_5678, "R8");
    send(64'hFFFF_0000_0000_0000, "R8");
    drain();

    // R3/R4/R5 memory window 0 (128 MiB) and I/O window 1
    wr(0, 1, 32'h0); wr(0, 2, 32'h4000_0000); wr(0, 3, 32'h0000_0001);
    wr(0, 4, 32'hF800_0000); wr(0, 5, 32'h0); wr(0, 6, 32'h0020_0000);
    wr(0, 0, 32'hE800_0001);
    wr(1, 2, 32'h0000_0000); wr(1, 4, 32'hF800_0000); wr(1, 6, 32'h0000_0004);
    wr(1, 0, 32'hC000_0001);
    wr_ctrl(32'h1);
    send(64'h0000_0000_E812_3456, "R4");
    send(64'h0000_0007_EFFF_FFFC, "R4");
    send(64'h0000_0000_C000_1000, "R5");
    send(64'h0000_0000_0000_1000, "R7");
    send(64'h0000_0000_F000_0000, "R7");
    drain();

    // R3 bit 0 excluded from compare; full mask window 2
    wr(2, 1, 32'h0000_0012); wr(2, 2, 32'h0000_ABC0); wr(2, 3, 32'h0000_0099);
    wr(2, 4, 32'hFFFF_FFFF); wr(2, 5, 32'hFFFF_FFFF); wr(2, 6, 32'h0000_0000);
    wr(2, 0, 32'h3456_7891);
    send(64'h0000_0012_3456_7890, "R3");
    send(64'h0000_0012_3456_7891, "R3");
    send(64'h0000_0012_3456_7892, "R3");
    drain();

    // R6 overlap: window 5 catches all, windows 0/1/2 keep priority
    wr(5, 2, 32'h0); wr(5, 4, 32'h0); wr(5, 5, 32'h0); wr(5, 6, 32'h0000_0055);
    wr(5, 0, 32'h1);
    send(64'h0000_0000_E800_0010, "R6");
    send(64'h0000_0000_C123_0000, "R6");
    send(64'h0000_0000_0000_2000, "R6");
    drain();

    // R10 window 0 disabled -> falls to window 5
    wr(0, 0, 32'hE800_0000);
    send(64'h0000_0000_E800_0010, "R10");
    drain();

    // R9 backpressure stream
    bp_on = 1;
    for (int i = 0; i < 24; i++)
      send({32'(i * 7), 32'hC000_0000 + 32'(i * 32'h0100_0000)}, "R9");
    drain();
    bp_on = 0;

    // R8 global off again
    wr_ctrl(32'h0);
    send(64'h0000_0000_C000_1000, "R8");
    send(64'h0000_0012_3456_7890, "R8");
    drain();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule